// File: doc/BRIEF.md
# Serial ADC Control-Byte Framer

This block is the device-facing serial front end of an 8-bit multichannel converter whose bit timing comes from the host's serial clock. The host holds chip select low and clocks bits into the data input on the serial clock. Chip select going low does not begin a frame. Low bits on the data input are skipped until a high bit arrives. That high bit opens an 8-bit control byte and becomes the byte's most significant bit. When the eighth bit is in, the next falling edge of the serial clock starts a conversion. At that edge the parallel sample input, which stands in for the analog core, is captured. The captured value is then driven out most significant bit first, one bit per falling edge.

Once the first result bit is on the data output, the block looks for start bits again. The host can therefore send the next control byte while the current result is still leaving. This supports back-to-back framing at 10 serial clocks per conversion and at the 16 clocks per conversion that byte-oriented hosts prefer. Raising chip select abandons any frame or conversion in progress. The last control byte that was fully received stays where it is.

All three serial inputs are resynchronised into the block clock and their edges are detected there. The serial clock must therefore run well below the block clock.

Top module: `serial_adc_framer`

## Requirements
- R1: A falling edge on chip select does nothing by itself. Zero bits sampled on the data input before a start bit are ignored: busy stays 0, the data output stays 0 and the control byte output is unchanged.
- R2: The data input is sampled on the rising edge of the serial clock while chip select is low. When the block is hunting, the first 1 sampled is the start bit. That bit and the next seven bits form the control byte. After the eighth bit, the byte appears on ctrl_o with the start bit at bit 7 and the last received bit (the power-down select bit) at bit 0.
- R3: A conversion starts on the serial clock falling edge that follows the eighth control bit. Busy goes to 1 at that edge and sample_i is captured at that edge.
- R4: The result changes only on falling edges of the serial clock. B7 appears on the falling edge after the conversion starts. B6 through B0 follow, one per falling edge.
- R5: Busy is 0 after reset. It stays 1 from the conversion start until the falling edge after B0, where it returns to 0. The data output is 0 whenever busy is 0.
- R6: During a conversion, high bits on the data input are ignored until B7 has been driven. The first high bit sampled after that starts the next control byte.
- R7: Back-to-back conversions work at both 10 and 16 serial clocks per conversion. Each control byte starts with its start bit on the first clock of its slot, and each result is the sample captured at its own conversion start.
- R8: A rising edge on chip select aborts any control byte or conversion in progress. Busy and the data output go to 0 and hunting restarts. ctrl_o keeps the last completed byte. The next high bit with chip select low begins a new frame.
- R9: While chip select is high, serial clock and data input activity has no effect on busy, the data output or ctrl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial data from the host |
| sample_i | input | DATA_W | Parallel sample standing in for the analog core |
| dout_o | output | 1 | Serial result data, 0 when idle |
| busy_o | output | 1 | High from conversion start until B0 has been shifted out |
| ctrl_o | output | CTRL_W | Most recently completed control byte |

## Verification
The assertions assume the following about the inputs:
- Each high and low phase of the serial clock lasts longer than the synchroniser latency, so that every edge is seen once.
- The data input changes no later than the serial clock's rising edge.
- Chip select changes only while the serial clock is low.

Under these assumptions the data output and busy change only after a detected falling edge or an abort, and the control byte changes only after a detected rising edge. The bench holds each serial clock phase for six block clocks. It changes the data input together with the rising edge and toggles chip select only with the serial clock low, so every edge the design detects is one the host intended.

// File: rtl/serial_adc_pkg.sv
package serial_adc_pkg;
  localparam int CtrlWidth = 8;
  localparam int DataWidth = 8;
  localparam int SyncStages = 2;

  typedef enum logic [1:0] {
    FRM_HUNT,
    FRM_SHIFT,
    FRM_WAIT,
    FRM_HOLD
  } frm_state_e;
endpackage

// File: rtl/serial_adc_sync.sv
module serial_adc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ff_q <= {STAGES{RST_VAL}};
        end else begin
          ff_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
        end
      end
      assign q_o = ff_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl
  import serial_adc_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  input  logic              msb_out_i,
  output logic              conv_start_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam int CntW = (CTRL_W > 1) ? $clog2(CTRL_W) : 1;

  frm_state_e        state_q;
  logic [CntW-1:0]   cnt_q;
  logic [CTRL_W-1:0] sh_q;
  logic [CTRL_W-1:0] next_sh;

  assign next_sh      = {sh_q[CTRL_W-2:0], din_i};
  assign conv_start_o = fall_i && (state_q == FRM_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FRM_HUNT;
      cnt_q   <= '0;
      sh_q    <= '0;
      ctrl_o  <= '0;
    end else if (abort_i) begin
      state_q <= FRM_HUNT;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        FRM_HUNT: if (rise_i && din_i) begin
          sh_q    <= {{(CTRL_W-1){1'b0}}, 1'b1};
          cnt_q   <= CntW'(1);
          state_q <= FRM_SHIFT;
        end
        FRM_SHIFT: if (rise_i) begin
          sh_q <= next_sh;
          if (cnt_q == CntW'(CTRL_W - 1)) begin
            ctrl_o  <= next_sh;
            cnt_q   <= '0;
            state_q <= FRM_WAIT;
          end else begin
            cnt_q <= cnt_q + CntW'(1);
          end
        end
        FRM_WAIT: if (fall_i) state_q <= FRM_HOLD;
        // start bits are locked out until the result MSB is on the line
        FRM_HOLD: if (msb_out_i) state_q <= FRM_HUNT;
        default: state_q <= FRM_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/serial_adc_out.sv
module serial_adc_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              fall_i,
  input  logic              conv_start_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              busy_o,
  output logic              msb_out_o
);
  localparam int CntW = $clog2(DATA_W + 1);

  logic [CntW-1:0]   cnt_q;
  logic [DATA_W-1:0] sh_q;

  assign msb_out_o = fall_i && busy_o && (cnt_q == CntW'(DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      dout_o <= 1'b0;
      busy_o <= 1'b0;
    end else if (abort_i) begin
      cnt_q  <= '0;
      dout_o <= 1'b0;
      busy_o <= 1'b0;
    end else if (conv_start_i) begin
      // a new start wins over the tail of the previous result
      sh_q   <= sample_i;
      cnt_q  <= CntW'(DATA_W);
      dout_o <= 1'b0;
      busy_o <= 1'b1;
    end else if (fall_i && busy_o) begin
      if (cnt_q != '0) begin
        dout_o <= sh_q[DATA_W-1];
        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
        cnt_q  <= cnt_q - CntW'(1);
      end else begin
        dout_o <= 1'b0;
        busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_adc_framer.sv
module serial_adc_framer
  import serial_adc_pkg::*;
#(
  parameter int CTRL_W      = CtrlWidth,
  parameter int DATA_W      = DataWidth,
  parameter int SYNC_STAGES = SyncStages
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              busy_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic cs_s, sclk_s, din_s;
  logic cs_prev_q, sclk_prev_q;
  logic rise_ev, fall_ev, abort;
  logic conv_start, msb_out;

  serial_adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i, .rst_ni, .d_i(cs_ni), .q_o(cs_s)
  );
  serial_adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i, .rst_ni, .d_i(sclk_i), .q_o(sclk_s)
  );
  serial_adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
    .clk_i, .rst_ni, .d_i(din_i), .q_o(din_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_s;
      sclk_prev_q <= sclk_s;
    end
  end

  assign rise_ev = sclk_s && !sclk_prev_q && !cs_s;
  assign fall_ev = !sclk_s && sclk_prev_q && !cs_s;
  assign abort   = cs_s && !cs_prev_q;

  serial_adc_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk_i,
    .rst_ni,
    .abort_i     (abort),
    .rise_i      (rise_ev),
    .fall_i      (fall_ev),
    .din_i       (din_s),
    .msb_out_i   (msb_out),
    .conv_start_o(conv_start),
    .ctrl_o
  );

  serial_adc_out #(.DATA_W(DATA_W)) u_out (
    .clk_i,
    .rst_ni,
    .abort_i     (abort),
    .fall_i      (fall_ev),
    .conv_start_i(conv_start),
    .sample_i,
    .dout_o,
    .busy_o,
    .msb_out_o   (msb_out)
  );
endmodule

// File: rtl/serial_adc_framer_chk.sv
module serial_adc_framer_chk #(
  parameter int CTRL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              dout_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              rise_ev,
  input logic              fall_ev,
  input logic              abort
);
  AST_IDLE_DOUT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dout_o) else $error("idle dout high"); // R5

  AST_BUSY_STARTS_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(fall_ev)) else $error("busy rose off a fall"); // R3

  AST_DOUT_MOVES_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_o) |-> ($past(fall_ev) || $past(abort))) else $error("dout moved off a fall"); // R4

  AST_CTRL_MOVES_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(rise_ev)) else $error("ctrl moved off a rise"); // R2

  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!busy_o && !dout_o)) else $error("abort left busy"); // R8

  AST_ABORT_KEEPS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> $stable(ctrl_o)) else $error("abort touched ctrl"); // R8
endmodule

bind serial_adc_framer serial_adc_framer_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk_i, .rst_ni, .busy_o, .dout_o, .ctrl_o, .rise_ev, .fall_ev, .abort
);

// File: tb/serial_adc_framer_test.sv
`timescale 1ns/1ps
module serial_adc_framer_test;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic [7:0] smp = 8'h00;
  logic dout, busy;
  logic [7:0] ctrl;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [7:0] s_ctrl [0:7];
  logic [7:0] s_smp  [0:7];

  // {ctrl byte, sample, leading zero clocks}
  localparam logic [23:0] VEC [0:5] = '{
    24'h81_5A_00, 24'hFE_A5_03, 24'hC3_00_01,
    24'h8F_FF_07, 24'hB6_01_02, 24'hE1_80_05
  };

  always #10 clk = ~clk;

  serial_adc_framer uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .din_i(din),
    .sample_i(smp), .dout_o(dout), .busy_o(busy), .ctrl_o(ctrl)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic d);
    din  = d;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) tick(b[i]);
  endtask

  task automatic cs_pulse();
    cs_ni = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy && !dout, "R8", "busy/dout after abort", {busy, dout}, 0);
    cs_ni = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_stream(input int frames, input int per, input string tag);
    for (int c = 1; c <= frames * per + 9; c++) begin
      int f   = (c - 1) / per;
      int pos = (c - 1) % per;
      logic d = 1'b0;
      if (f < frames && pos < 8) d = s_ctrl[f][7-pos];
      if (f < frames && pos == 0) smp = s_smp[f];
      tick(d);
      if (f < frames && pos == 7) begin
        chk(ctrl == s_ctrl[f], tag, "R2 control byte", ctrl, s_ctrl[f]);
        chk(busy == 1'b1, "R3", "busy at conversion start", busy, 1);
        chk(dout == 1'b0, "R4", "dout before MSB", dout, 0);
      end
      if (c >= 9) begin
        int g = (c - 9) / per;
        int q = (c - 9) % per;
        if (g < frames && q < 8) begin
          chk(dout == s_smp[g][7-q], "R4", $sformatf("%s bit B%0d", tag, 7 - q),
              dout, s_smp[g][7-q]);
          chk(busy == 1'b1, "R5", "busy while shifting", busy, 1);
        end
        if (g < frames && q == 8)
          chk(busy == 1'b0, "R5", "busy after B0", busy, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !dout && ctrl == 8'h00, "R5", "reset state", {busy, dout, ctrl}, 0);

    // R1: chip select falling alone, then zeros
    cs_ni = 1'b0;
    repeat (12) @(negedge clk);
    chk(!busy, "R1", "busy after cs fall", busy, 0);
    for (int i = 0; i < 12; i++) tick(1'b0);
    chk(!busy && !dout && ctrl == 8'h00, "R1", "zeros ignored", {busy, dout, ctrl}, 0);

    // table walk: single frames with leading zeros
    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < int'(VEC[v][7:0]); i++) begin
        tick(1'b0);
        chk(!busy && !dout, "R1", "leading zero", {busy, dout}, 0);
      end
      s_ctrl[0] = VEC[v][23:16];
      s_smp[0]  = VEC[v][15:8];
      run_stream(1, 10, "R2");
    end

    // R7: back-to-back streams
    for (int i = 0; i < 6; i++) begin
      s_ctrl[i] = 8'h80 | 8'(i * 23 + 5);
      s_smp[i]  = 8'(i * 61 + 17);
    end
    run_stream(6, 10, "R7 10clk");
    for (int i = 0; i < 4; i++) begin
      s_ctrl[i] = 8'h80 | 8'(i * 37 + 9);
      s_smp[i]  = 8'(255 - i * 45);
    end
    run_stream(4, 16, "R7 16clk");

    // R6: high bit before MSB is out is not a start bit
    smp = 8'h3C;
    send_byte(8'hC3);
    tick(1'b1);
    chk(dout == 1'b0, "R6", "B7 of 3C", dout, 0);
    for (int i = 0; i < 10; i++) tick(1'b0);
    chk(ctrl == 8'hC3 && !busy, "R6", "no false frame", {busy, ctrl}, 8'hC3);

    // R8: abort during result
    smp = 8'h96;
    send_byte(8'h9D);
    tick(1'b0);
    tick(1'b0);
    chk(busy == 1'b1, "R8", "busy before abort", busy, 1);
    cs_pulse();
    chk(ctrl == 8'h9D, "R8", "ctrl kept", ctrl, 8'h9D);
    s_ctrl[0] = 8'hA7;
    s_smp[0]  = 8'h4B;
    run_stream(1, 16, "R8 after abort");

    // R8: abort during control shift
    tick(1'b1); tick(1'b0); tick(1'b1); tick(1'b1);
    cs_pulse();
    chk(ctrl == 8'hA7, "R8", "partial byte dropped", ctrl, 8'hA7);
    s_ctrl[0] = 8'h8E;
    s_smp[0]  = 8'hD2;
    run_stream(1, 10, "R8 restart");

    // R9: chip select high blocks everything
    cs_ni = 1'b1;
    repeat (6) @(negedge clk);
    send_byte(8'hFF);
    for (int i = 0; i < 10; i++) begin
      tick(1'b1);
      chk(!busy && !dout, "R9", "cs high activity", {busy, dout}, 0);
    end
    chk(ctrl == 8'h8E, "R9", "ctrl untouched", ctrl, 8'h8E);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule